// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This unit holds the doorbell state that lets processors in a cluster interrupt one another. Each CPU owns two doorbells. The "other" doorbell is rung by any CPU on any group of targets in one write. The "self" doorbell can be rung only by the CPU that owns it. Every doorbell has a pending bit and a mask bit. The unit drives one interrupt line per CPU, which is high while that CPU has at least one pending doorbell that is not masked.

Software reaches the unit through a single register bus. The bus carries the index of the CPU making the access, and every register works on that CPU's own state. A read of the event register reports the highest-priority visible doorbell as a typed event word, and that read also masks the doorbell it reports. Software then clears the doorbell with an acknowledge write and unmasks it when it is ready to take the next one. The number of CPUs is a parameter, with a limit of 31.

Top module: `ipi_unit`

## Requirements
- R1: After reset no doorbell is pending, both mask bits of every CPU are set, every `ipiIrq` bit is low, and event reads return 0.
- R2: A write to offset 0x2008 with bit n set (n < NUM_CPUS) sets the "other" pending bit of CPU n. Several targets can be named in one write. Bits for CPUs that do not exist have no effect. A send to a CPU whose bit is already pending leaves one pending bit, so a single acknowledge clears it.
- R3: Bit 31 of a write to 0x2008 sets the "self" pending bit of the writing CPU only.
- R4: A write to offset 0x200C affects only the accessing CPU. Bit 0 clears its "other" pending bit and bit 31 clears its "self" pending bit.
- R5: A write to offset 0x2024 sets mask bits and a write to 0x2028 clears them, with bit 0 for "other" and bit 31 for "self". A masked doorbell stays pending but is not visible. It becomes visible again once it is unmasked.
- R6: A read at offset 0x2004 returns 0x0004 in bits 31:16 and a low field of 1 for "other" or 2 for "self". "Other" is reported when both doorbells are visible. The read returns 0 when no doorbell is visible.
- R7: An event read that reports a doorbell sets that doorbell's mask bit, and the change takes effect from the next cycle.
- R8: `ipiIrq[i]` is high exactly when CPU i has a pending doorbell that is not masked.
- R9: Accesses with `busCpu` >= NUM_CPUS are ignored and read 0. Writes to other offsets are ignored, and reads at any offset other than 0x2004 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busCpu | input | CPU_W | Index of the CPU making the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (an event read has side effects) |
| busAddr | input | 16 | Register offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational in the access cycle |
| ipiIrq | output | NUM_CPUS | Interrupt line for each CPU |

## Verification
The bench builds the unit with NUM_CPUS = 5, which makes `busCpu` three bits wide. Indices 5 to 7 can then be driven to exercise the rule that accesses from absent CPUs are ignored. With five CPUs, send bits 5 to 30 belong to no CPU, so one write can mix real and absent targets. Five CPUs also leave room for several senders to ring the same target and for the self-doorbell to be checked against its neighbours.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;
  localparam logic [15:0] OFF_EVENT = 16'h2004;
  localparam logic [15:0] OFF_SEND  = 16'h2008;
  localparam logic [15:0] OFF_ACK   = 16'h200C;
  localparam logic [15:0] OFF_MSET  = 16'h2024;
  localparam logic [15:0] OFF_MCLR  = 16'h2028;

  localparam logic [15:0] EVT_KIND_IPI = 16'd4;
  localparam logic [15:0] EVT_OTHER    = 16'd1;
  localparam logic [15:0] EVT_SELF     = 16'd2;

  localparam int OTHER_BIT = 0;
  localparam int SELF_BIT  = 31;

  typedef struct packed {
    logic send;
    logic ack;
    logic maskSet;
    logic maskClr;
    logic evtRead;
  } ipiStrobes_t;
endpackage

// File: rtl/ipi_ctrl.sv
`timescale 1ns/1ps
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int CPU_W    = 3
) (
  input  logic [CPU_W-1:0] busCpu,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [15:0]      busAddr,
  output ipiStrobes_t      stb
);
  localparam logic [CPU_W-1:0] LAST_CPU = CPU_W'(NUM_CPUS - 1);

  logic cpuValid;
  assign cpuValid = (busCpu <= LAST_CPU);

  always_comb begin
    stb         = '0;
    stb.send    = cpuValid && busWrEn && (busAddr == OFF_SEND);
    stb.ack     = cpuValid && busWrEn && (busAddr == OFF_ACK);
    stb.maskSet = cpuValid && busWrEn && (busAddr == OFF_MSET);
    stb.maskClr = cpuValid && busWrEn && (busAddr == OFF_MCLR);
    stb.evtRead = cpuValid && busRdEn && (busAddr == OFF_EVENT);
  end
endmodule

// File: rtl/ipi_datapath.sv
`timescale 1ns/1ps
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int CPU_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ipiStrobes_t         stb,
  input  logic [CPU_W-1:0]    busCpu,
  input  logic [31:0]         busWrData,
  output logic [31:0]         rdData,
  output logic [NUM_CPUS-1:0] irq,
  output logic [NUM_CPUS-1:0] pendOther,
  output logic [NUM_CPUS-1:0] pendSelf,
  output logic [NUM_CPUS-1:0] maskOther,
  output logic [NUM_CPUS-1:0] maskSelf
);
  logic [NUM_CPUS-1:0] visOther;
  logic [NUM_CPUS-1:0] visSelf;

  assign visOther = pendOther & ~maskOther;
  assign visSelf  = pendSelf & ~maskSelf;
  assign irq      = visOther | visSelf;

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    logic hit;
    logic pO, pS, mO, mS;
    logic repOther, repSelf;

    assign hit      = (busCpu == CPU_W'(i));
    assign repOther = stb.evtRead && hit && visOther[i];
    assign repSelf  = stb.evtRead && hit && !visOther[i] && visSelf[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pO <= 1'b0;
        pS <= 1'b0;
        mO <= 1'b1;
        mS <= 1'b1;
      end else begin
        if (stb.send && busWrData[i])
          pO <= 1'b1;
        else if (stb.ack && hit && busWrData[OTHER_BIT])
          pO <= 1'b0;

        if (stb.send && hit && busWrData[SELF_BIT])
          pS <= 1'b1;
        else if (stb.ack && hit && busWrData[SELF_BIT])
          pS <= 1'b0;

        if ((stb.maskSet && hit && busWrData[OTHER_BIT]) || repOther)
          mO <= 1'b1;
        else if (stb.maskClr && hit && busWrData[OTHER_BIT])
          mO <= 1'b0;

        if ((stb.maskSet && hit && busWrData[SELF_BIT]) || repSelf)
          mS <= 1'b1;
        else if (stb.maskClr && hit && busWrData[SELF_BIT])
          mS <= 1'b0;
      end
    end

    assign pendOther[i] = pO;
    assign pendSelf[i]  = pS;
    assign maskOther[i] = mO;
    assign maskSelf[i]  = mS;
  end

  logic selOther, selSelf;
  always_comb begin
    selOther = 1'b0;
    selSelf  = 1'b0;
    for (int i = 0; i < NUM_CPUS; i++) begin
      if (busCpu == CPU_W'(i)) begin
        selOther = visOther[i];
        selSelf  = visSelf[i];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.evtRead) begin
      if (selOther)
        rdData = {EVT_KIND_IPI, EVT_OTHER};
      else if (selSelf)
        rdData = {EVT_KIND_IPI, EVT_SELF};
    end
  end
endmodule

// File: rtl/ipi_unit.sv
`timescale 1ns/1ps
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int CPU_W    = $clog2(NUM_CPUS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_W-1:0]    busCpu,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [15:0]         busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  output logic [NUM_CPUS-1:0] ipiIrq
);
  ipiStrobes_t         stb;
  logic [NUM_CPUS-1:0] pendOther, pendSelf, maskOther, maskSelf;

  ipi_ctrl #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_ctrl (
    .busCpu (busCpu),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .stb    (stb)
  );

  ipi_datapath #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .busCpu   (busCpu),
    .busWrData(busWrData),
    .rdData   (busRdData),
    .irq      (ipiIrq),
    .pendOther(pendOther),
    .pendSelf (pendSelf),
    .maskOther(maskOther),
    .maskSelf (maskSelf)
  );
endmodule

// File: rtl/ipi_unit_chk.sv
`timescale 1ns/1ps
module ipi_unit_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int CPU_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CPU_W-1:0]    busCpu,
  input logic                busWrEn,
  input logic                busRdEn,
  input logic [15:0]         busAddr,
  input logic [31:0]         busWrData,
  input logic [31:0]         busRdData,
  input logic [NUM_CPUS-1:0] ipiIrq,
  input logic [NUM_CPUS-1:0] pendOther,
  input logic [NUM_CPUS-1:0] pendSelf,
  input logic [NUM_CPUS-1:0] maskOther,
  input logic [NUM_CPUS-1:0] maskSelf
);
  logic validCpu;
  assign validCpu = (int'(busCpu) < NUM_CPUS);

  // R6: any non-zero read carries the doorbell event kind
  p_evt_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdData != 32'd0) |-> (busRdData[31:16] == EVT_KIND_IPI));

  // R9: absent CPUs read zero
  p_absent_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !validCpu |-> (busRdData == 32'd0));

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_chk
    // R2: a send naming CPU i leaves its other-doorbell pending
    p_send_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (validCpu && busWrEn && busAddr == OFF_SEND && busWrData[i]) |=> pendOther[i]);

    // R3: self bit pends the writer's own doorbell
    p_self_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busWrEn && busAddr == OFF_SEND && busWrData[SELF_BIT] && busCpu == CPU_W'(i))
      |=> pendSelf[i]);

    // R4: acknowledge of bit 0 clears the other-doorbell
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busWrEn && busAddr == OFF_ACK && busWrData[OTHER_BIT] && busCpu == CPU_W'(i))
      |=> !pendOther[i]);

    // R7: reporting the other-doorbell masks it
    p_evt_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busRdEn && busAddr == OFF_EVENT && busCpu == CPU_W'(i) &&
       busRdData == {EVT_KIND_IPI, EVT_OTHER}) |=> maskOther[i]);

    // R5: a masked doorbell never drives the line by itself
    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (maskOther[i] && maskSelf[i]) |-> !ipiIrq[i]);
  end
endmodule

bind ipi_unit ipi_unit_chk #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busCpu(busCpu), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .ipiIrq(ipiIrq),
  .pendOther(pendOther), .pendSelf(pendSelf), .maskOther(maskOther), .maskSelf(maskSelf)
);

// File: tb/tb_ipi_unit.sv
`timescale 1ns/1ps
module tb_ipi_unit;
  localparam int N = 5;
  localparam int CW = $clog2(N + 1);
  localparam logic [15:0] A_EVT = 16'h2004, A_SEND = 16'h2008, A_ACK = 16'h200C,
                          A_MSET = 16'h2024, A_MCLR = 16'h2028;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] busCpu = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [N-1:0] ipiIrq;

  always #2.5 clk = ~clk;

  ipi_unit #(.NUM_CPUS(N)) dut (
    .clk(clk), .rst_n(rst_n), .busCpu(busCpu), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .ipiIrq(ipiIrq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit mO[N], mS[N], kO[N], kS[N];

  initial for (int i = 0; i < N; i++) begin mO[i] = 0; mS[i] = 0; kO[i] = 1; kS[i] = 1; end

  function automatic logic [31:0] modelEvt(int c);
    if (c >= N) return 32'd0;
    if (mO[c] && !kO[c]) return 32'h0004_0001;
    if (mS[c] && !kS[c]) return 32'h0004_0002;
    return 32'd0;
  endfunction

  function automatic logic [N-1:0] modelIrq();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (mO[i] && !kO[i]) || (mS[i] && !kS[i]);
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R8: line compared with the model on every clock
  always @(negedge clk) if (rst_n && !done)
    check(ipiIrq == modelIrq(), "R8 irq", 32'(ipiIrq), 32'(modelIrq()));

  // one bus access, started and ended at a falling edge
  task automatic access(int c, bit we, bit re, logic [15:0] a, logic [31:0] d, string tag);
    logic [31:0] ev;
    busCpu = CW'(c); busWrEn = we; busRdEn = re; busAddr = a; busWrData = d;
    ev = modelEvt(c);
    #1;
    if (re) check(busRdData == ((a == A_EVT) ? ev : 32'd0), tag, busRdData,
                  (a == A_EVT) ? ev : 32'd0);
    @(posedge clk);
    if (c < N) begin
      if (we && a == A_SEND) begin
        for (int t = 0; t < N; t++) if (d[t]) mO[t] = 1;
        if (d[31]) mS[c] = 1;
      end
      if (we && a == A_ACK) begin
        if (d[0]) mO[c] = 0;
        if (d[31]) mS[c] = 0;
      end
      if (we && a == A_MSET) begin
        if (d[0]) kO[c] = 1;
        if (d[31]) kS[c] = 1;
      end
      if (we && a == A_MCLR) begin
        if (d[0]) kO[c] = 0;
        if (d[31]) kS[c] = 0;
      end
      if (re && a == A_EVT) begin
        if (ev == 32'h0004_0001) kO[c] = 1;
        else if (ev == 32'h0004_0002) kS[c] = 1;
      end
    end
    @(negedge clk);
    busWrEn = 0; busRdEn = 0;
  endtask

  task automatic evtRead(int c, string tag);
    access(c, 0, 1, A_EVT, 32'd0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ipiIrq == '0, "R1 irq after reset", 32'(ipiIrq), 32'd0);
    for (int c = 0; c < N; c++) evtRead(c, "R1 event after reset");

    // R5: masked doorbell stays hidden, appears on unmask
    access(0, 1, 0, A_SEND, 32'h0000_0002, "R5 send masked");
    check(ipiIrq == '0, "R5 masked hidden", 32'(ipiIrq), 32'd0);
    evtRead(1, "R5 masked event zero");
    access(1, 1, 0, A_MCLR, 32'h0000_0001, "R5 unmask");
    check(ipiIrq[1] == 1'b1, "R5 visible after unmask", 32'(ipiIrq), 32'h2);

    for (int c = 0; c < N; c++) access(c, 1, 0, A_MCLR, 32'h8000_0001, "R5 unmask all");

    // R2: multi-target send with an absent target bit
    access(2, 1, 0, A_SEND, 32'h0000_021D, "R2 multi send");
    check(ipiIrq == 5'b11111, "R2 targets pending", 32'(ipiIrq), 32'h1F);

    // R2: merge of repeated sends, one ack clears
    access(4, 1, 0, A_SEND, 32'h0000_0008, "R2 resend");
    access(3, 1, 0, A_ACK, 32'h0000_0001, "R2 single ack");
    check(ipiIrq[3] == 1'b0, "R2 merged cleared", 32'(ipiIrq), 32'h17);

    // R3: self doorbell only on the writer
    access(3, 1, 0, A_SEND, 32'h8000_0000, "R3 self send");
    check(ipiIrq[3] == 1'b1, "R3 self on writer", 32'(ipiIrq), 32'h1F);

    // R6/R7: priority and masking on report
    access(1, 1, 0, A_SEND, 32'h0000_0008, "R6 other on cpu3");
    evtRead(3, "R6 other first");
    evtRead(3, "R6 self next");
    evtRead(3, "R7 both masked read zero");
    check(ipiIrq[3] == 1'b0, "R7 line low after reports", 32'(ipiIrq), 32'h17);
    access(3, 1, 0, A_MCLR, 32'h0000_0001, "R5 re-unmask other");
    evtRead(3, "R6 other again");

    // R4: acknowledge clears only the accessing CPU
    access(3, 1, 0, A_MCLR, 32'h8000_0000, "R4 unmask self");
    access(3, 1, 0, A_ACK, 32'h8000_0001, "R4 ack both");
    check(ipiIrq[3] == 1'b0, "R4 cpu3 cleared", 32'(ipiIrq), 32'h17);
    check(ipiIrq[2] == 1'b1, "R4 neighbour kept", 32'(ipiIrq), 32'h17);

    // R9: absent CPUs and unused offsets
    access(6, 1, 0, A_SEND, 32'h8000_0008, "R9 absent send");
    check(ipiIrq[3] == 1'b0, "R9 absent send ignored", 32'(ipiIrq), 32'h17);
    access(7, 1, 0, A_MCLR, 32'h8000_0001, "R9 absent mask");
    evtRead(6, "R9 absent read zero");
    access(0, 1, 0, 16'h2010, 32'h0000_0008, "R9 other offset write");
    check(ipiIrq[3] == 1'b0, "R9 offset write ignored", 32'(ipiIrq), 32'h17);
    access(0, 0, 1, A_SEND, 32'd0, "R9 non-event read zero");

    // R5: mask set hides a pending doorbell, clear brings it back
    access(0, 1, 0, A_MSET, 32'h0000_0001, "R5 mask set");
    check(ipiIrq[0] == 1'b0, "R5 mask set hides", 32'(ipiIrq), 32'h16);
    access(0, 1, 0, A_MCLR, 32'h0000_0001, "R5 mask clear");
    check(ipiIrq[0] == 1'b1, "R5 mask clear shows", 32'(ipiIrq), 32'h17);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule